// File: doc/BRIEF.md
# Mode-Banked Register File

This block is a sixteen-entry general register file whose upper registers are shadowed per processor mode. A five-bit mode input picks one of several banks. When the bank changes, the block saves the shadowed registers that are leaving the live view and restores the ones that are entering it, in a single clock edge. Two asynchronous read ports and one write port always act on the live view of the current mode.

The banks are not all the same size. The fast-interrupt bank shadows r8 to r14. The user, interrupt, supervisor, abort and undefined banks shadow only r13 and r14. System mode shares the user copies, and any unrecognised mode falls into a dummy bank whose r8 to r14 read as zero on entry. A debug port reads or writes the register that a named mode would see. This works whether or not that mode is active. A separate port reads and writes the saved-status word of each exception bank. Banks without one answer with the current status word instead.

Top module: `shadow_regfile`

## Requirements
- R1: After reset the current mode is 5'b10011 (supervisor), and every live register, shadow copy and saved-status word is zero.
- R2: Mode decoding: 0 and 16 select user, 1 and 17 fast-interrupt, 2 and 18 interrupt, 3 and 19 supervisor, 23 abort, 27 undefined, 31 system (sharing user storage), and every other value the dummy bank.
- R3: mode_o shows the mode_i sampled at the previous edge. Reads in the cycle that requests a switch return the values from before the switch.
- R4: The user, interrupt, supervisor, abort and undefined banks each keep a private r13 and r14. These are saved on leaving the bank and restored on entering it. System mode uses the user pair.
- R5: The fast-interrupt bank keeps its own r8 to r14. Entering it from another bank first saves live r8 to r12 as the user copy. Leaving it for a non-dummy bank restores r8 to r12 from that copy.
- R6: Entering the dummy bank sets live r8 to r14 to zero. A debug access from another bank that names a dummy-bank mode reads zero, and its write is ignored.
- R7: A mode change between two modes of the same bank (system and user count as one) moves no register.
- R8: Write-port data lands in the live register at the edge, and both read ports return live registers combinationally. r0 to r7 and r15 are shared by every mode.
- R9: A debug access naming a mode of the current bank uses the live registers. For another bank, r0 to r7 and r15 are live. r8 to r14 of the fast-interrupt bank are its copy. r13 and r14 of another bank are its pair. r8 to r12 of a non-fast bank are the user copy while fast-interrupt is active, and live otherwise.
- R10: Within one cycle, the write port applies first, then the debug write (which wins on the same location), then the bank switch.
- R11: A saved-status word exists only for the fast-interrupt, interrupt, supervisor, abort and undefined banks. For any other mode a read returns cur_status_i and a write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Requested mode, taken at each edge |
| mode_o | output | 5 | Current mode |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write port enable |
| wr_addr_i | input | 4 | Write port register number |
| wr_data_i | input | 32 | Write port data |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_mode_i | input | 5 | Mode named by the debug access |
| dbg_addr_i | input | 4 | Debug register number |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_rdata_o | output | 32 | Debug read data |
| psr_we_i | input | 1 | Saved-status write enable |
| psr_mode_i | input | 5 | Mode whose saved status is accessed |
| psr_wdata_i | input | 32 | Saved-status write data |
| psr_rdata_o | output | 32 | Saved-status read data |
| cur_status_i | input | 32 | Current status word, returned for banks without a saved copy |

## Verification
The assertions assume that every input is a known value from the first edge after reset. They also assume that mode_i may move to any encoding on any cycle, so a bank switch can coincide with a write-port or debug write. The restore check for fast-interrupt exit is guarded so that it applies only in cycles with no write of either kind. The stimulus changes inputs only at the falling edge and never drives unknown values. It mixes directed sequences with a long pseudo-random run that is biased toward the decoded modes, but still hits unrecognised ones.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5,
        BK_SYS = 3'd6,
        BK_DUM = 3'd7
    } bank_e;

    typedef enum logic [2:0] {
        LOC_NONE,
        LOC_LIVE,
        LOC_FIQ,
        LOC_UHI,
        LOC_SP,
        LOC_LR
    } loc_e;

    localparam int          NBANK      = 8;
    localparam int          FIQ_FIRST  = 8;
    localparam int          PAIR_FIRST = 13;
    localparam int          LAST_SHAD  = 14;
    localparam logic [4:0]  RESET_MODE = 5'b10011;

    // system shares user storage
    function automatic bank_e norm_bank(bank_e b);
        return (b == BK_SYS) ? BK_USR : b;
    endfunction

    function automatic logic has_status(bank_e b);
        return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
               (b == BK_ABT) || (b == BK_UND);
    endfunction

endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import rf_bank_pkg::*;
#(
    parameter int MW = 5
) (
    input  logic [MW-1:0] mode_i,
    output bank_e         bank_o
);

    always_comb begin
        unique case (mode_i)
            MW'(0),  MW'(16): bank_o = BK_USR;
            MW'(1),  MW'(17): bank_o = BK_FIQ;
            MW'(2),  MW'(18): bank_o = BK_IRQ;
            MW'(3),  MW'(19): bank_o = BK_SVC;
            MW'(23):          bank_o = BK_ABT;
            MW'(27):          bank_o = BK_UND;
            MW'(31):          bank_o = BK_SYS;
            default:          bank_o = BK_DUM;
        endcase
    end

endmodule

// File: rtl/rf_status_bank.sv
module rf_status_bank
    import rf_bank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_e         bank_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] cur_status_i,
    output logic [DW-1:0] rdata_o
);

    typedef struct packed {
        logic [NBANK-1:0][DW-1:0] saved;
    } st_t;

    st_t  st_d, st_q;
    logic present;

    assign present = has_status(bank_i);

    always_comb begin
        st_d = st_q;
        if (we_i && present) begin
            st_d.saved[bank_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = present ? st_q.saved[bank_i] : cur_status_i;

    // R11
    status_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !present) |=> $stable(st_q.saved));

    // R11
    status_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && present) |=> (st_q.saved[$past(bank_i)] == $past(wdata_i)));

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import rf_bank_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int MW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode_i,
    output logic [MW-1:0] mode_o,
    input  logic [AW-1:0] rd_a_addr_i,
    output logic [DW-1:0] rd_a_data_o,
    input  logic [AW-1:0] rd_b_addr_i,
    output logic [DW-1:0] rd_b_data_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          dbg_we_i,
    input  logic [MW-1:0] dbg_mode_i,
    input  logic [AW-1:0] dbg_addr_i,
    input  logic [DW-1:0] dbg_wdata_i,
    output logic [DW-1:0] dbg_rdata_o,
    input  logic          psr_we_i,
    input  logic [MW-1:0] psr_mode_i,
    input  logic [DW-1:0] psr_wdata_i,
    output logic [DW-1:0] psr_rdata_o,
    input  logic [DW-1:0] cur_status_i
);

    localparam int NREG = 1 << AW;
    localparam int NFIQ = LAST_SHAD - FIQ_FIRST + 1;
    localparam int NUHI = PAIR_FIRST - FIQ_FIRST;
    localparam int NDEC = 4;
    localparam int IOFW = $clog2(NFIQ);

    typedef struct packed {
        logic [MW-1:0]             mode;
        logic [NREG-1:0][DW-1:0]   live;
        logic [NFIQ-1:0][DW-1:0]   fiq;
        logic [NUHI-1:0][DW-1:0]   uhi;
        logic [NBANK-1:0][DW-1:0]  sp;
        logic [NBANK-1:0][DW-1:0]  lr;
    } state_t;

    state_t s_d, s_q;

    // decoders: current, requested, debug, status
    logic [MW-1:0] dec_mode [NDEC];
    bank_e         dec_bank [NDEC];

    assign dec_mode[0] = s_q.mode;
    assign dec_mode[1] = mode_i;
    assign dec_mode[2] = dbg_mode_i;
    assign dec_mode[3] = psr_mode_i;

    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        rf_mode_decode #(.MW(MW)) u_dec (
            .mode_i (dec_mode[g]),
            .bank_o (dec_bank[g])
        );
    end

    bank_e cur_b, nxt_b, dbg_b;
    logic  bank_chg;

    assign cur_b    = norm_bank(dec_bank[0]);
    assign nxt_b    = norm_bank(dec_bank[1]);
    assign dbg_b    = norm_bank(dec_bank[2]);
    assign bank_chg = (cur_b != nxt_b);

    // where the debug-addressed register physically lives
    loc_e          dbg_loc;
    logic [AW-1:0] dbg_off;
    logic [IOFW-1:0] dbg_idx;

    assign dbg_off = dbg_addr_i - AW'(FIQ_FIRST);
    assign dbg_idx = dbg_off[IOFW-1:0];

    always_comb begin
        if (dbg_b == cur_b) begin
            dbg_loc = LOC_LIVE;
        end else if (dbg_b == BK_DUM) begin
            dbg_loc = LOC_NONE;
        end else if ((int'(dbg_addr_i) < FIQ_FIRST) || (int'(dbg_addr_i) > LAST_SHAD)) begin
            dbg_loc = LOC_LIVE;
        end else if (dbg_b == BK_FIQ) begin
            dbg_loc = LOC_FIQ;
        end else if (int'(dbg_addr_i) == PAIR_FIRST) begin
            dbg_loc = LOC_SP;
        end else if (int'(dbg_addr_i) == LAST_SHAD) begin
            dbg_loc = LOC_LR;
        end else if (cur_b == BK_FIQ) begin
            dbg_loc = LOC_UHI;
        end else begin
            dbg_loc = LOC_LIVE;
        end
    end

    always_comb begin
        unique case (dbg_loc)
            LOC_LIVE: dbg_rdata_o = s_q.live[dbg_addr_i];
            LOC_FIQ:  dbg_rdata_o = s_q.fiq[dbg_idx];
            LOC_UHI:  dbg_rdata_o = s_q.uhi[dbg_idx];
            LOC_SP:   dbg_rdata_o = s_q.sp[dbg_b];
            LOC_LR:   dbg_rdata_o = s_q.lr[dbg_b];
            default:  dbg_rdata_o = '0;
        endcase
    end

    // next state: write port, then debug write, then bank switch
    state_t mid;

    always_comb begin
        mid = s_q;
        if (wr_en_i) begin
            mid.live[wr_addr_i] = wr_data_i;
        end
        if (dbg_we_i) begin
            unique case (dbg_loc)
                LOC_LIVE: mid.live[dbg_addr_i] = dbg_wdata_i;
                LOC_FIQ:  mid.fiq[dbg_idx]     = dbg_wdata_i;
                LOC_UHI:  mid.uhi[dbg_idx]     = dbg_wdata_i;
                LOC_SP:   mid.sp[dbg_b]        = dbg_wdata_i;
                LOC_LR:   mid.lr[dbg_b]        = dbg_wdata_i;
                default:  ;
            endcase
        end

        s_d = mid;
        if (bank_chg) begin
            // save the outgoing bank
            if (cur_b == BK_FIQ) begin
                for (int i = 0; i < NFIQ; i++) begin
                    s_d.fiq[i] = mid.live[FIQ_FIRST + i];
                end
            end else if (cur_b != BK_DUM) begin
                if (nxt_b == BK_FIQ) begin
                    for (int i = 0; i < NUHI; i++) begin
                        s_d.uhi[i] = mid.live[FIQ_FIRST + i];
                    end
                end
                s_d.sp[cur_b] = mid.live[PAIR_FIRST];
                s_d.lr[cur_b] = mid.live[LAST_SHAD];
            end
            // restore the incoming bank
            if (nxt_b == BK_FIQ) begin
                for (int i = 0; i < NFIQ; i++) begin
                    s_d.live[FIQ_FIRST + i] = mid.fiq[i];
                end
            end else if (nxt_b == BK_DUM) begin
                for (int i = FIQ_FIRST; i <= LAST_SHAD; i++) begin
                    s_d.live[i] = '0;
                end
            end else begin
                if (cur_b == BK_FIQ) begin
                    for (int i = 0; i < NUHI; i++) begin
                        s_d.live[FIQ_FIRST + i] = mid.uhi[i];
                    end
                end
                s_d.live[PAIR_FIRST] = mid.sp[nxt_b];
                s_d.live[LAST_SHAD]  = mid.lr[nxt_b];
            end
        end
        s_d.mode = mode_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= RESET_MODE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o      = s_q.mode;
    assign rd_a_data_o = s_q.live[rd_a_addr_i];
    assign rd_b_data_o = s_q.live[rd_b_addr_i];

    rf_status_bank #(.DW(DW)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_i       (dec_bank[3]),
        .we_i         (psr_we_i),
        .wdata_i      (psr_wdata_i),
        .cur_status_i (cur_status_i),
        .rdata_o      (psr_rdata_o)
    );

    // R3
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mode_o == $past(mode_i)));

    // R6
    dummy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_chg && nxt_b == BK_DUM) |=>
            (s_q.live[FIQ_FIRST] == '0 && s_q.live[PAIR_FIRST] == '0 && s_q.live[LAST_SHAD] == '0));

    // R7
    no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_chg && !wr_en_i && !dbg_we_i) |=> $stable(s_q.live));

    // R5
    fiq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_chg && cur_b == BK_FIQ && nxt_b != BK_DUM && !wr_en_i && !dbg_we_i) |=>
            (s_q.live[FIQ_FIRST] == $past(s_q.uhi[0])));

    // R4
    pair_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_chg && cur_b != BK_FIQ && cur_b != BK_DUM && !wr_en_i && !dbg_we_i) |=>
            (s_q.sp[$past(cur_b)] == $past(s_q.live[PAIR_FIRST])));

endmodule

// File: tb/shadow_regfile_tb.sv
`timescale 1ns/1ps
module shadow_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'd19;
    logic [4:0]  mode_o;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        dbg_we = 1'b0;
    logic [4:0]  dbg_mode = '0;
    logic [3:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        psr_we = 1'b0;
    logic [4:0]  psr_mode = '0;
    logic [31:0] psr_wdata = '0;
    logic [31:0] psr_rdata;
    logic [31:0] cur_status = 32'hC0DE_0000;

    always #4 clk = ~clk;

    shadow_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_o(mode_o),
        .rd_a_addr_i(rd_a_addr), .rd_a_data_o(rd_a_data),
        .rd_b_addr_i(rd_b_addr), .rd_b_data_o(rd_b_data),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .dbg_we_i(dbg_we), .dbg_mode_i(dbg_mode), .dbg_addr_i(dbg_addr),
        .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata),
        .psr_we_i(psr_we), .psr_mode_i(psr_mode), .psr_wdata_i(psr_wdata),
        .psr_rdata_o(psr_rdata), .cur_status_i(cur_status)
    );

    int    n_tests = 0, n_fail = 0, cnt = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model: 0 usr,1 fiq,2 irq,3 svc,4 abt,5 und,7 dummy
    logic [31:0] m_live [16];
    logic [31:0] m_fiq  [16];
    logic [31:0] m_usr  [16];
    logic [31:0] m_sp   [8];
    logic [31:0] m_lr   [8];
    logic [31:0] m_spsr [8];
    int          m_mode;

    function automatic int bank_of(int m);
        case (m)
            0, 16, 31: return 0;
            1, 17:     return 1;
            2, 18:     return 2;
            3, 19:     return 3;
            23:        return 4;
            27:        return 5;
            default:   return 7;
        endcase
    endfunction

    function automatic logic [31:0] mread(int b, int a);
        int cb = bank_of(m_mode);
        if (b == cb) return m_live[a];
        if (b == 7) return 32'h0;
        if (a < 8 || a == 15) return m_live[a];
        if (b == 1) return m_fiq[a];
        if (a == 13) return m_sp[b];
        if (a == 14) return m_lr[b];
        if (cb == 1) return m_usr[a];
        return m_live[a];
    endfunction

    task automatic mwrite(int b, int a, logic [31:0] d);
        int cb = bank_of(m_mode);
        if (b == cb) m_live[a] = d;
        else if (b == 7) ;
        else if (a < 8 || a == 15) m_live[a] = d;
        else if (b == 1) m_fiq[a] = d;
        else if (a == 13) m_sp[b] = d;
        else if (a == 14) m_lr[b] = d;
        else if (cb == 1) m_usr[a] = d;
        else m_live[a] = d;
    endtask

    function automatic bit has_psr(int b);
        return b >= 1 && b <= 5;
    endfunction

    task automatic model_clk();
        int ob = bank_of(m_mode);
        int nb = bank_of(int'(mode_i));
        if (wr_en) m_live[wr_addr] = wr_data;
        if (dbg_we) mwrite(bank_of(int'(dbg_mode)), int'(dbg_addr), dbg_wdata);
        if (ob != nb) begin
            if (ob == 1) begin
                for (int i = 8; i <= 14; i++) m_fiq[i] = m_live[i];
            end else if (ob != 7) begin
                if (nb == 1) for (int i = 8; i <= 12; i++) m_usr[i] = m_live[i];
                m_sp[ob] = m_live[13];
                m_lr[ob] = m_live[14];
            end
            if (nb == 1) begin
                for (int i = 8; i <= 14; i++) m_live[i] = m_fiq[i];
            end else if (nb == 7) begin
                for (int i = 8; i <= 14; i++) m_live[i] = 32'h0;
            end else begin
                if (ob == 1) for (int i = 8; i <= 12; i++) m_live[i] = m_usr[i];
                m_live[13] = m_sp[nb];
                m_live[14] = m_lr[nb];
            end
        end
        if (psr_we && has_psr(bank_of(int'(psr_mode)))) m_spsr[bank_of(int'(psr_mode))] = psr_wdata;
        m_mode = int'(mode_i);
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // compare all outputs, then advance one clock
    task automatic step();
        logic [31:0] pexp;
        rd_a_addr = 4'(cnt);
        rd_b_addr = 4'(cnt * 7 + 3);
        if (!dbg_we) begin
            dbg_mode = 5'(cnt * 5 + 1);
            dbg_addr = 4'(cnt * 3 + 8);
        end
        if (!psr_we) psr_mode = 5'(cnt * 3);
        cur_status = 32'hC0DE_0000 | 32'(cnt);
        #1;
        chk("rd_a", rd_a_data, m_live[rd_a_addr]);
        chk("rd_b", rd_b_data, m_live[rd_b_addr]);
        chk("dbg_rdata", dbg_rdata, mread(bank_of(int'(dbg_mode)), int'(dbg_addr)));
        pexp = has_psr(bank_of(int'(psr_mode))) ? m_spsr[bank_of(int'(psr_mode))] : cur_status;
        chk("psr_rdata", psr_rdata, pexp);
        chk("mode_o", 32'(mode_o), 32'(m_mode));
        @(posedge clk);
        model_clk();
        @(negedge clk);
        cnt++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_en = 1; wr_addr = 4'(a); wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic go(int m);
        mode_i = 5'(m);
        step();
    endtask

    task automatic dwr(int m, int a, logic [31:0] d);
        dbg_we = 1; dbg_mode = 5'(m); dbg_addr = 4'(a); dbg_wdata = d;
        step();
        dbg_we = 0;
    endtask

    initial begin
        int ml [12] = '{0, 16, 1, 17, 2, 18, 3, 19, 23, 27, 31, 5};
        for (int i = 0; i < 16; i++) begin
            m_live[i] = 0; m_fiq[i] = 0; m_usr[i] = 0;
        end
        for (int i = 0; i < 8; i++) begin
            m_sp[i] = 0; m_lr[i] = 0; m_spsr[i] = 0;
        end
        m_mode = 19;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        idle(16);

        cur_req = "R8";
        for (int i = 0; i < 16; i++) wr(i, 32'h1000_0000 + 32'(i * 17));
        idle(16);

        cur_req = "R4";
        go(16); wr(13, 32'hAAAA_0013); wr(14, 32'hAAAA_0014);
        go(18); wr(13, 32'hBBBB_0013); wr(14, 32'hBBBB_0014);
        go(23); wr(13, 32'hCCCC_0013);
        go(27); wr(14, 32'hDDDD_0014);
        go(31); idle(16);
        go(19); idle(16);
        go(18); idle(16);

        cur_req = "R3";
        mode_i = 5'd23; rd_a_addr = 4'd13;
        step();
        go(23); idle(4);

        cur_req = "R5";
        go(0); wr(8, 32'h5555_0008); wr(12, 32'h5555_0012);
        go(17); idle(16);
        for (int i = 8; i <= 14; i++) wr(i, 32'hF1F1_0000 + 32'(i));
        go(2); idle(16);
        go(1); idle(16);
        go(3); idle(16);

        cur_req = "R6";
        dwr(9, 13, 32'hDEAD_BEEF);
        go(5); idle(16);
        wr(9, 32'h7777_0009);
        go(12); idle(4);
        go(17); idle(16);
        go(16); idle(16);

        cur_req = "R7";
        wr(13, 32'h0707_0013);
        go(0); go(31); go(16); idle(16);
        go(17); go(1); idle(16);

        cur_req = "R9";
        dwr(19, 13, 32'h9999_0013);
        dwr(17, 10, 32'h9999_0010);
        dwr(16, 9, 32'h9999_0009);
        dwr(1, 4, 32'h9999_0004);
        idle(32);
        go(19); idle(32);

        cur_req = "R10";
        wr_en = 1; wr_addr = 4'd13; wr_data = 32'h1010_AAAA;
        dbg_we = 1; dbg_mode = 5'd19; dbg_addr = 4'd13; dbg_wdata = 32'h1010_BBBB;
        mode_i = 5'd18;
        step();
        wr_en = 0; dbg_we = 0;
        go(19); idle(16);

        cur_req = "R11";
        for (int m = 0; m < 32; m++) begin
            psr_we = 1; psr_mode = 5'(m); psr_wdata = 32'h5150_0000 | 32'(m);
            step();
        end
        psr_we = 0;
        idle(32);

        cur_req = "R2";
        for (int m = 0; m < 32; m++) begin
            go(m);
            wr(8, 32'h2000_0000 | 32'(m));
            wr(13, 32'h2D00_0000 | 32'(m));
        end
        idle(16);
        for (int i = 0; i < 1500; i++) begin
            int r = int'($urandom % 100);
            mode_i = (r < 15) ? 5'($urandom) : (r < 50 ? 5'(ml[$urandom % 12]) : mode_i);
            wr_en = ($urandom % 2) == 0;
            wr_addr = 4'($urandom); wr_data = $urandom;
            dbg_we = ($urandom % 5) == 0;
            dbg_mode = 5'(ml[$urandom % 12]); dbg_addr = 4'($urandom); dbg_wdata = $urandom;
            psr_we = ($urandom % 5) == 0;
            psr_mode = 5'($urandom); psr_wdata = $urandom;
            step();
        end
        wr_en = 0; dbg_we = 0; psr_we = 0;
        idle(16);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule